// File: doc/BRIEF.md
# Dual ALU Execution Stage with Latched Compare Flag

This block is the 32-bit arithmetic stage of a small multi-cycle processor datapath. It holds two combinational units that share a pair of operands: a primary arithmetic unit that a 2-bit function code steers, and a secondary logic unit that a single select bit steers. Two drive enables decide which unit's result is placed on the single result bus. When neither enable is set, the bus reads zero.

A condition evaluator watches the bus while the primary unit computes a difference of the operands. It produces one true/false bit for equality, signed less-than or signed greater-than. A load strobe captures that bit into a one-bit flag register on the clock edge. The sequencer can then use the stored decision in the following cycle to choose whether to branch.

Top module: `exec_unit_top`

## Requirements
- R1: With `alu_fn` = 2'b00 and `drv_alu` = 1, `bus_out` equals `opa + opb`, modulo 2^WIDTH.
- R2: With `alu_fn` = 2'b01 and `drv_alu` = 1, `bus_out` equals `opa - opb`, modulo 2^WIDTH.
- R3: With `alu_fn` = 2'b10 and `drv_alu` = 1, `bus_out` equals the bitwise NAND of `opa` and `opb`.
- R4: With `alu_fn` = 2'b11 and `drv_alu` = 1, `bus_out` equals `opa + 1` and wraps from all ones to zero; `opb` has no effect.
- R5: With only `drv_lu` = 1, `bus_out` is `opa | opb` when `lu_sel` = 0 and `opa ^ opb` when `lu_sel` = 1.
- R6: With both drive enables low, `bus_out` is zero.
- R7: With both drive enables high, `bus_out` carries the primary unit's result.
- R8: `cond_sel` = 2'b00 tests equality: the evaluated bit is 1 exactly when the bus value is zero.
- R9: `cond_sel` = 2'b01 tests signed less-than and `cond_sel` = 2'b10 tests signed greater-than of `opa` against `opb`. The test uses the sign of the bus difference corrected by the subtraction overflow, so it stays correct when the difference overflows.
- R10: `cond_sel` = 2'b11 always evaluates to 0.
- R11: On a rising edge with `cmp_load` = 1, `cmp_flag` takes the evaluated bit. It shows that value from the cycle after the edge.
- R12: On a rising edge with `cmp_load` = 0, `cmp_flag` keeps its value.
- R13: A rising edge with `rst` = 1 clears `cmp_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| alu_fn | input | 2 | Primary unit function: add, subtract, NAND, increment |
| lu_sel | input | 1 | Logic unit select: 0 OR, 1 XOR |
| drv_alu | input | 1 | Place the primary result on the bus |
| drv_lu | input | 1 | Place the logic unit result on the bus |
| cond_sel | input | 2 | Condition to test: equal, less, greater, none |
| cmp_load | input | 1 | Capture the evaluated condition into the flag |
| bus_out | output | WIDTH | Shared result bus |
| cmp_flag | output | 1 | Latched compare decision |

## Verification
The only state in the block is the one-bit flag. If that flag is wrong, `cmp_flag` shows it in the cycle right after the loading edge, so every compare test samples the flag one edge after the strobe. A corrupted carry or an operand-select fault shows up at once on `bus_out` within the same cycle. The signed tests use operand pairs whose difference overflows, because a fault that reads only the raw sign bit would return the inverted answer for exactly those pairs. Hold tests change the operands while the strobe is low. This exposes a flag that reloads when it should not.

// File: rtl/exec_unit_pkg.sv
package exec_unit_pkg;
  typedef enum logic [1:0] {
    FN_ADD  = 2'b00,
    FN_SUB  = 2'b01,
    FN_NAND = 2'b10,
    FN_INC  = 2'b11
  } alu_fn_e;

  typedef enum logic [1:0] {
    CND_EQ   = 2'b00,
    CND_LT   = 2'b01,
    CND_GT   = 2'b10,
    CND_NONE = 2'b11
  } cond_e;
endpackage

// File: rtl/prim_alu.sv
module prim_alu
  import exec_unit_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_fn_e          fn,
  output logic [WIDTH-1:0] y
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // one adder shared by add, subtract and increment
  logic [WIDTH-1:0] addend;
  logic             cin;
  logic [WIDTH-1:0] sum;

  always_comb begin
    addend = b;
    cin    = 1'b0;
    unique case (fn)
      FN_SUB:  begin addend = ~b; cin = 1'b1; end
      FN_INC:  begin addend = ONE; cin = 1'b0; end
      default: begin addend = b;  cin = 1'b0; end
    endcase
  end

  assign sum = a + addend + {{(WIDTH-1){1'b0}}, cin};

  always_comb begin
    if (fn == FN_NAND) y = ~(a & b);
    else               y = sum;
  end
endmodule

// File: rtl/logic_unit.sv
module logic_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sel,
  output logic [WIDTH-1:0] y
);
  assign y = sel ? (a ^ b) : (a | b);
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import exec_unit_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] diff,
  input  logic             a_msb,
  input  logic             b_msb,
  input  cond_e            sel,
  output logic             hit
);
  localparam int MSB = WIDTH - 1;

  logic is_zero, ovf, neg;

  assign is_zero = (diff == '0);
  // subtraction overflows when operand signs differ and result sign differs from a
  assign ovf     = (a_msb != b_msb) && (diff[MSB] != a_msb);
  assign neg     = diff[MSB] ^ ovf;

  always_comb begin
    unique case (sel)
      CND_EQ:  hit = is_zero;
      CND_LT:  hit = neg;
      CND_GT:  hit = !neg && !is_zero;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/exec_unit_top.sv
module exec_unit_top
  import exec_unit_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       alu_fn,
  input  logic             lu_sel,
  input  logic             drv_alu,
  input  logic             drv_lu,
  input  logic [1:0]       cond_sel,
  input  logic             cmp_load,
  output logic [WIDTH-1:0] bus_out,
  output logic             cmp_flag
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] alu_res;
  logic [WIDTH-1:0] lu_res;
  logic             cond_hit;

  prim_alu #(.WIDTH(WIDTH)) u_alu (
    .a  (opa),
    .b  (opb),
    .fn (alu_fn_e'(alu_fn)),
    .y  (alu_res)
  );

  logic_unit #(.WIDTH(WIDTH)) u_lu (
    .a   (opa),
    .b   (opb),
    .sel (lu_sel),
    .y   (lu_res)
  );

  // primary unit wins when both enables are set
  always_comb begin
    if (drv_alu)     bus_out = alu_res;
    else if (drv_lu) bus_out = lu_res;
    else             bus_out = '0;
  end

  cond_eval #(.WIDTH(WIDTH)) u_cond (
    .diff  (bus_out),
    .a_msb (opa[MSB]),
    .b_msb (opb[MSB]),
    .sel   (cond_e'(cond_sel)),
    .hit   (cond_hit)
  );

  always_ff @(posedge clk) begin
    if (rst)           cmp_flag <= 1'b0;
    else if (cmp_load) cmp_flag <= cond_hit;
  end
endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [1:0]       alu_fn,
  input logic             drv_alu,
  input logic             drv_lu,
  input logic [1:0]       cond_sel,
  input logic             cmp_load,
  input logic [WIDTH-1:0] bus_out,
  input logic             cmp_flag,
  input logic [WIDTH-1:0] alu_res
);
  a_r6_bus_idle: assert property (@(posedge clk) disable iff (rst)
    (!drv_alu && !drv_lu) |-> (bus_out == '0));

  a_r7_conflict_primary: assert property (@(posedge clk) disable iff (rst)
    (drv_alu && drv_lu) |-> (bus_out == alu_res));

  a_r12_hold_flag: assert property (@(posedge clk) disable iff (rst)
    !cmp_load |=> $stable(cmp_flag));

  a_r10_none_clears: assert property (@(posedge clk) disable iff (rst)
    (cmp_load && cond_sel == 2'b11) |=> !cmp_flag);

  a_r8_equal_flag: assert property (@(posedge clk) disable iff (rst)
    (cmp_load && cond_sel == 2'b00 && drv_alu && !drv_lu && alu_fn == 2'b01)
      |=> (cmp_flag == ($past(opa) == $past(opb))));
endmodule

bind exec_unit_top exec_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opa      (opa),
  .opb      (opb),
  .alu_fn   (alu_fn),
  .drv_alu  (drv_alu),
  .drv_lu   (drv_lu),
  .cond_sel (cond_sel),
  .cmp_load (cmp_load),
  .bus_out  (bus_out),
  .cmp_flag (cmp_flag),
  .alu_res  (alu_res)
);

// File: tb/tb_exec_unit_top.sv
module tb_exec_unit_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] opa, opb;
  logic [1:0]   alu_fn, cond_sel;
  logic         lu_sel, drv_alu, drv_lu, cmp_load;
  logic [W-1:0] bus_out;
  logic         cmp_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  exec_unit_top #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .alu_fn(alu_fn),
    .lu_sel(lu_sel), .drv_alu(drv_alu), .drv_lu(drv_lu),
    .cond_sel(cond_sel), .cmp_load(cmp_load),
    .bus_out(bus_out), .cmp_flag(cmp_flag)
  );

  task automatic chk_bus(input string req, input logic [W-1:0] exp);
    checks++;
    if (bus_out !== exp) begin
      errors++;
      $display("FAIL %s bus actual=%h expected=%h", req, bus_out, exp);
    end
  endtask

  task automatic chk_flag(input string req, input logic exp);
    checks++;
    if (cmp_flag !== exp) begin
      errors++;
      $display("FAIL %s flag actual=%b expected=%b", req, cmp_flag, exp);
    end
  endtask

  task automatic idle();
    drv_alu = 0; drv_lu = 0; cmp_load = 0; cond_sel = 2'b11;
    alu_fn = 2'b00; lu_sel = 0;
  endtask

  // drive at negedge, look at combinational bus shortly after
  task automatic bus_case(input string req, input logic [1:0] fn, input logic ls,
                          input logic da, input logic dl,
                          input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] exp);
    @(negedge clk);
    opa = a; opb = b; alu_fn = fn; lu_sel = ls; drv_alu = da; drv_lu = dl;
    cmp_load = 0;
    #2 chk_bus(req, exp);
  endtask

  // subtract on bus, strobe load, check flag one edge later
  task automatic cmp_case(input string req, input logic [1:0] cs,
                          input logic [W-1:0] a, input logic [W-1:0] b);
    logic exp;
    case (cs)
      2'b00:   exp = (a == b);
      2'b01:   exp = ($signed(a) < $signed(b));
      2'b10:   exp = ($signed(a) > $signed(b));
      default: exp = 1'b0;
    endcase
    @(negedge clk);
    opa = a; opb = b; alu_fn = 2'b01; drv_alu = 1; drv_lu = 0;
    cond_sel = cs; cmp_load = 1;
    @(negedge clk);
    cmp_load = 0;
    chk_flag(req, exp);
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst = 1; idle();
    @(negedge clk);
    chk_flag("R13 reset", 1'b0);
    chk_bus("R6 idle after reset", '0);
    rst = 0;
  endtask

  task automatic test_arith();
    bus_case("R1 add", 2'b00, 0, 1, 0, 32'h0000_1234, 32'h0000_0111, 32'h0000_1345);
    bus_case("R1 add wrap", 2'b00, 0, 1, 0, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001);
    bus_case("R2 sub", 2'b01, 0, 1, 0, 32'h0000_0010, 32'h0000_0011, 32'hFFFF_FFFF);
    bus_case("R3 nand", 2'b10, 0, 1, 0, 32'hF0F0_FFFF, 32'hFF00_0F0F, 32'h0FFF_F0F0);
    bus_case("R4 inc", 2'b11, 0, 1, 0, 32'h0000_0041, 32'hDEAD_BEEF, 32'h0000_0042);
    bus_case("R4 inc wrap", 2'b11, 0, 1, 0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0000);
  endtask

  task automatic test_logic_and_bus();
    bus_case("R5 or", 2'b00, 0, 0, 1, 32'hA5A5_0000, 32'h0F0F_00FF, 32'hAFAF_00FF);
    bus_case("R5 xor", 2'b00, 1, 0, 1, 32'hA5A5_0000, 32'h0F0F_00FF, 32'hAAAA_00FF);
    bus_case("R6 no driver", 2'b00, 1, 0, 0, 32'h1111_1111, 32'h2222_2222, 32'h0);
    bus_case("R7 both drivers", 2'b10, 1, 1, 1, 32'hFFFF_0000, 32'hFF00_FF00, 32'h00FF_FFFF);
  endtask

  task automatic test_compare();
    cmp_case("R8 equal true", 2'b00, 32'h0000_0777, 32'h0000_0777);
    cmp_case("R8 equal false", 2'b00, 32'h0000_0777, 32'h0000_0776);
    cmp_case("R9 lt plain", 2'b01, 32'hFFFF_FFFE, 32'h0000_0003);
    cmp_case("R9 lt overflow", 2'b01, 32'h8000_0000, 32'h0000_0001);
    cmp_case("R9 lt false when equal", 2'b01, 32'h0000_0005, 32'h0000_0005);
    cmp_case("R9 gt overflow", 2'b10, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    cmp_case("R9 gt false when equal", 2'b10, 32'h0000_0005, 32'h0000_0005);
    cmp_case("R9 gt false when less", 2'b10, 32'h8000_0000, 32'h7FFF_FFFF);
    cmp_case("R11 set before none", 2'b00, 32'h0000_0009, 32'h0000_0009);
    cmp_case("R10 none", 2'b11, 32'h0000_0009, 32'h0000_0009);
  endtask

  task automatic test_hold_and_reset();
    cmp_case("R11 set", 2'b01, 32'hFFFF_FFF0, 32'h0000_0001);
    @(negedge clk);
    opa = 32'h0000_0100; opb = 32'h0000_0001; cond_sel = 2'b01;
    drv_alu = 1; alu_fn = 2'b01; cmp_load = 0;
    @(negedge clk);
    chk_flag("R12 hold one", 1'b1);
    @(negedge clk);
    chk_flag("R12 hold two", 1'b1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk_flag("R13 reset clears set flag", 1'b0);
  endtask

  initial begin
    rst = 1; opa = '0; opb = '0; idle();
    test_reset();
    test_arith();
    test_logic_and_bus();
    test_compare();
    test_hold_and_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule